// File: doc/BRIEF.md
# Prescaled Compare Timer

An up-counter runs from a divided count-tick input. Three compare channels watch the count. Each channel owns one output pin and drives it according to its own action mode: leave it alone, toggle it, drive it low, drive it high, or emit an active-low pulse that lasts one divided tick. Software reaches the block through a flat set of word registers. A write uses a strobe, an address and a data word. A read is combinational from a separate read address.

The counter has two counting modes. It can run freely through its whole range, in which case it raises a wrap flag when it passes from all ones back to zero. It can also restart from zero on the divided tick after it has matched compare channel 0. A start-behaviour bit decides whether turning the timer on clears the count or resumes from the held value. A force strobe applies a channel's pin action at once, without waiting for a match.

Each event flag has its own interrupt enable, and a single interrupt line combines them. A self-clearing soft-reset bit puts the whole block back to its power-on state.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: The divide ratio is the value in register 1, bits [11:0], plus one, so the ratio ranges from 1 to 4096. While the timer runs, the count advances once for each ratio-many clock cycles that have `tick_in` high. It does not advance while `tick_in` is low.
- R2: When the run bit (register 0, bit 0) is clear, the count and the divider hold their values.
- R3: In free-run mode (register 0, bit 1 clear), the count steps from all ones to 0 and sets the wrap flag, which is register 2, bit 3.
- R4: In restart mode (register 0, bit 1 set), a divided tick that finds the count equal to compare 0 (register 4) loads 0 instead of incrementing. Matches on compare 1 (register 5) and compare 2 (register 6) never restart the count.
- R5: Register 0, bit 2 selects the start behaviour. If it is set when the run bit goes from 0 to 1, the count is zeroed. If it is clear, the count keeps its held value.
- R6: On a divided tick where the count (readable at register 7) equals compare channel i, flag i (register 2, bit i) is set. The count seen is the value before that tick's increment.
- R7: On a match, the pin mode of channel i (register 0, bits [3i+6:3i+4]) acts on `cmp_out[i]`. Mode 0 leaves the pin unchanged, 1 inverts it, 2 drives it 0 and 3 drives it 1. All pins reset to 0.
- R8: Mode 4 drives the pin to 0 at the match. The pin returns to 1 at the next divided tick.
- R9: Writing 1 to register 0, bit 13+i applies channel i's stored mode to its pin at that write's clock edge. It sets no flag, and these bits read back as 0.
- R10: Writing 1 to a bit of register 2 clears that flag. Flag bits written with 0 are not affected.
- R11: `irq` is high exactly when some flag is set and its enable bit in register 3 (same bit position) is also set.
- R12: Writing 1 to register 0, bit 3 makes that bit read 1 for one cycle. On the next edge, every register, the count and the pins return to their reset values, and the bit reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Count tick qualifier, divided by the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| cmp_out | output | 3 | Compare channel output pins |
| irq | output | 1 | Combined interrupt |

## Verification
The wrap is the hardest event to reach from the ports, because the count cannot be written and a full-width counter would need billions of ticks to get there. The bench therefore builds the block with an 8-bit counter and runs it in free-run mode from zero. It checks the count and the wrap flag one cycle before the wrap and again at the wrap. The end of a pulse is similar: it depends on the next divided tick, not on the next clock. The bench first forces the pin high, then uses a ratio of 2 so that it can see the low phase span two clocks before the pin returns high.

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [2:0]  cmp_out,
  output logic        irq
);
  localparam int NCH = 3;
  localparam int NFL = NCH + 1;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_DIV   = 3'd1;
  localparam logic [2:0] A_FLAGS = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_CMP0  = 3'd4;
  localparam logic [2:0] A_CNT   = 3'd7;
  localparam logic [2:0] M_TOG = 3'd1, M_LOW = 3'd2, M_HIGH = 3'd3, M_PULSE = 3'd4;

  logic                      run, restart, zstart, srst_q;
  logic [NCH-1:0][2:0]       mode;
  logic [PS_W-1:0]           div_m1, pcnt;
  logic [NFL-1:0]            flags, ien;
  logic [NCH-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]          cnt;
  logic [NCH-1:0]            pin, pend;

  wire             wr_ctrl     = wr_en && (wr_addr == A_CTRL);
  wire             ptick       = run && tick_in && (pcnt >= div_m1);
  wire             start       = wr_ctrl && wr_data[0] && !run && wr_data[2];
  wire [NFL-1:0]   flag_clr    = (wr_en && wr_addr == A_FLAGS) ? wr_data[NFL-1:0] : '0;
  wire [NCH-1:0]   force_s     = wr_ctrl ? wr_data[13 +: NCH] : '0;
  logic [NCH-1:0]  match;
  wire             restart_hit = restart && match[0];
  wire             wrap        = ptick && !restart_hit && (&cnt);

  always_comb
    for (int i = 0; i < NCH; i++) match[i] = ptick && (cnt == cmp[i]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; restart <= 1'b0; zstart <= 1'b0; srst_q <= 1'b0;
      mode <= '0; div_m1 <= '0; pcnt <= '0; flags <= '0; ien <= '0;
      cmp <= '0; cnt <= '0;
    end else if (srst_q) begin
      run <= 1'b0; restart <= 1'b0; zstart <= 1'b0; srst_q <= 1'b0;
      mode <= '0; div_m1 <= '0; pcnt <= '0; flags <= '0; ien <= '0;
      cmp <= '0; cnt <= '0;
    end else begin
      srst_q <= wr_ctrl && wr_data[3];
      if (wr_ctrl) begin
        run     <= wr_data[0];
        restart <= wr_data[1];
        zstart  <= wr_data[2];
        for (int i = 0; i < NCH; i++) mode[i] <= wr_data[4 + 3*i +: 3];
      end
      if (wr_en && wr_addr == A_DIV) div_m1 <= wr_data[PS_W-1:0];
      if (wr_en && wr_addr == A_IEN) ien <= wr_data[NFL-1:0];
      for (int i = 0; i < NCH; i++)
        if (wr_en && wr_addr == A_CMP0 + 3'(i)) cmp[i] <= wr_data[CNT_W-1:0];
      if (start)            cnt <= '0;
      else if (restart_hit) cnt <= '0;
      else if (ptick)       cnt <= cnt + 1'b1;
      if (start || ptick)       pcnt <= '0;
      else if (run && tick_in)  pcnt <= pcnt + 1'b1;
      flags <= (flags & ~flag_clr) | {wrap, match};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= '0; pend <= '0;
    end else if (srst_q) begin
      pin <= '0; pend <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ptick && pend[i]) begin
          pin[i]  <= 1'b1;
          pend[i] <= 1'b0;
        end
        if (match[i] || force_s[i]) begin
          case (mode[i])
            M_TOG:   begin pin[i] <= ~pin[i]; pend[i] <= 1'b0; end
            M_LOW:   begin pin[i] <= 1'b0;    pend[i] <= 1'b0; end
            M_HIGH:  begin pin[i] <= 1'b1;    pend[i] <= 1'b0; end
            M_PULSE: begin pin[i] <= 1'b0;    pend[i] <= 1'b1; end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {16'd0, 3'd0, mode[2], mode[1], mode[0], srst_q, zstart, restart, run};
      A_DIV:   rd_data = 32'(div_m1);
      A_FLAGS: rd_data = 32'(flags);
      A_IEN:   rd_data = 32'(ien);
      A_CNT:   rd_data = 32'(cnt);
      default: rd_data = 32'(cmp[rd_addr - A_CMP0]);
    endcase
  end

  assign cmp_out = pin;
  assign irq     = |(flags & ien);
endmodule

// File: rtl/prescaled_cmp_timer_props.sv
module prescaled_cmp_timer_props #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ptick,
  input logic             wr_ctrl,
  input logic             srst_q,
  input logic             restart,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp0,
  input logic [3:0]       flags,
  input logic             irq
);
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptick && !wr_ctrl && !srst_q) |=> $stable(cnt));

  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && ptick && (&cnt) && !srst_q) |=> flags[3]);

  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && ptick && cnt == cmp0 && !srst_q) |=> (cnt == '0));

  a_r6_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(ptick));

  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'd0) |-> !irq);

  a_r12_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
endmodule

bind prescaled_cmp_timer prescaled_cmp_timer_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .ptick(ptick), .wr_ctrl(wr_ctrl), .srst_q(srst_q),
  .restart(restart), .cnt(cnt), .cmp0(cmp[0]), .flags(flags), .irq(irq)
);

// File: tb/tb_prescaled_cmp_timer.sv
`timescale 1ns/1ps
module tb_prescaled_cmp_timer;
  logic        clk = 1'b0, rst_n = 1'b0, tick_in = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0]  cmp_out;
  logic        irq;
  int n_run = 0, n_fail = 0;
  logic [31:0] v, held;

  always #2.5 clk = ~clk;

  prescaled_cmp_timer #(.CNT_W(8), .PS_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cmp_out(cmp_out), .irq(irq)
  );

  // divider, compare value, expected cycles to first match
  localparam int VEC [7][3] = '{
    '{1, 0, 1}, '{1, 5, 6}, '{3, 4, 15}, '{2, 9, 20},
    '{7, 2, 21}, '{4096, 0, 4096}, '{1, 255, 256}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic soft_reset();
    wr(3'd0, 32'h8);
    step(1);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state
    chk("R7 reset pins", 32'(cmp_out), 32'd0);
    chk("R11 reset irq", 32'(irq), 32'd0);
    rd(3'd7, v); chk("R12 reset count", v, 32'd0);
    rd(3'd0, v); chk("R12 reset ctrl", v, 32'd0);

    // R1 / R6: table walk, toggle mode on channel 0, time to first match
    for (int i = 0; i < 7; i++) begin
      int n;
      soft_reset();
      wr(3'd1, 32'(VEC[i][0] - 1));
      wr(3'd4, 32'(VEC[i][1]));
      wr(3'd3, 32'h1);
      wr(3'd0, 32'h15);
      n = 0;
      while (!irq && n < 10000) begin step(1); n++; end
      chk($sformatf("R1 R6 vec%0d cycles", i), 32'(n), 32'(VEC[i][2]));
      chk($sformatf("R7 vec%0d toggle pin", i), 32'(cmp_out[0]), 32'd1);
    end

    // R1: tick_in low stops counting
    soft_reset();
    wr(3'd0, 32'h5);
    step(3);
    tick_in = 1'b0;
    rd(3'd7, held);
    step(5);
    rd(3'd7, v); chk("R1 tick low holds", v, held);
    tick_in = 1'b1;

    // R4: restart on compare 0, compare 1 does not restart
    soft_reset();
    wr(3'd4, 32'd3);
    wr(3'd5, 32'd1);
    wr(3'd0, 32'h7);
    step(2); rd(3'd7, v); chk("R4 ch1 no restart", v, 32'd2);
    step(2); rd(3'd7, v); chk("R4 restart to zero", v, 32'd0);
    step(1); rd(3'd7, v); chk("R4 count after restart", v, 32'd1);

    // R3: wrap in free-run
    soft_reset();
    wr(3'd0, 32'h5);
    step(255);
    rd(3'd7, v); chk("R3 count before wrap", v, 32'd255);
    rd(3'd2, v); chk("R3 no wrap flag yet", v & 32'h8, 32'h0);
    step(1);
    rd(3'd7, v); chk("R3 count wrapped", v, 32'd0);
    rd(3'd2, v); chk("R3 wrap flag", v & 32'h8, 32'h8);

    // R2: stop holds the count
    wr(3'd0, 32'h0);
    rd(3'd7, held);
    step(10);
    rd(3'd7, v); chk("R2 hold while stopped", v, held);
    // R5: resume without zeroing, then zero on start
    wr(3'd0, 32'h1);
    rd(3'd7, v); chk("R5 resume keeps count", v, held);
    step(3);
    rd(3'd7, v); chk("R5 counting resumed", v, held + 32'd3);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h5);
    rd(3'd7, v); chk("R5 start zeroes count", v, 32'd0);

    // R7: set / none / toggle on the same match
    soft_reset();
    wr(3'd4, 32'd2); wr(3'd5, 32'd2); wr(3'd6, 32'd2);
    wr(3'd0, 32'h435);
    step(3);
    chk("R7 set none toggle", 32'(cmp_out), 32'b101);
    rd(3'd2, v); chk("R6 all three flags", v, 32'h7);
    // R10: clear one flag only
    wr(3'd2, 32'h2);
    rd(3'd2, v); chk("R10 w1c one flag", v, 32'h5);
    // R11: irq gating
    wr(3'd3, 32'h2);
    chk("R11 enabled flag clear", 32'(irq), 32'd0);
    wr(3'd3, 32'h4);
    chk("R11 enabled flag set", 32'(irq), 32'd1);
    wr(3'd2, 32'hF);
    chk("R11 irq after clear", 32'(irq), 32'd0);
    // R9: force clear mode on channel 0
    wr(3'd0, 32'h25);
    wr(3'd0, 32'h2025);
    chk("R9 R7 forced clear", 32'(cmp_out), 32'b100);
    rd(3'd2, v); chk("R9 force sets no flag", v, 32'h0);
    rd(3'd0, v); chk("R9 force reads zero", v & 32'hE000, 32'h0);

    // R8: one-tick pulse with divide by 2
    soft_reset();
    wr(3'd1, 32'd1);
    wr(3'd6, 32'd2);
    wr(3'd0, 32'hC00);
    wr(3'd0, 32'h8C00);
    chk("R9 force high", 32'(cmp_out[2]), 32'd1);
    wr(3'd0, 32'h1005);
    step(5); chk("R8 before pulse", 32'(cmp_out[2]), 32'd1);
    step(1); chk("R8 pulse low", 32'(cmp_out[2]), 32'd0);
    step(1); chk("R8 pulse still low", 32'(cmp_out[2]), 32'd0);
    step(1); chk("R8 pulse ends", 32'(cmp_out[2]), 32'd1);

    // R12: soft reset self-clears and restores state
    wr(3'd0, 32'h100D);
    rd(3'd0, v); chk("R12 bit reads one", v & 32'h8, 32'h8);
    step(1);
    rd(3'd0, v); chk("R12 ctrl cleared", v, 32'h0);
    rd(3'd6, v); chk("R12 compare cleared", v, 32'h0);
    rd(3'd1, v); chk("R12 divider cleared", v, 32'h0);
    chk("R12 pins cleared", 32'(cmp_out), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule